// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR-style flash array and turns the host's bus write cycles into array operations. It follows the unlock prefixes and command bytes. When a sequence completes, it issues a single program or chip-erase request to the backing array and reports busy until the array says it is done. It also decides whether host reads see array data or identification data.

The block recognises five kinds of sequence. A standard program takes four writes and a chip erase takes six. Autoselect mode returns identification bytes. Unlock-bypass mode programs with two writes per location. A reset command abandons a partial sequence. While an embedded operation runs, every write is ignored. A low level on the hardware reset input stops everything at once and returns the block to array read. The embedded operation itself is a stub: the array model answers with a done pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After hardware reset (rst_n low), busy=0, op_req=0 and id_sel=0 (array read).
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then data D at address A form a standard program. They launch one single-cycle op_req with op_erase=0, op_addr=A and op_data=D. busy rises in the same cycle. Unlock addresses are compared on wr_addr[10:0] and commands on wr_data[7:0].
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h form a chip erase. They launch one op_req with op_erase=1, op_addr=0 and op_data all ones.
- R4: busy stays high from the launch cycle through the cycle in which op_done is sampled high, and falls on the next clock edge.
- R5: While busy, every write is ignored, including F0h and unlock writes. No partial sequence survives the operation.
- R6: A write with data F0h between the cycles of a program, erase or autoselect sequence returns the block to array read, and no operation follows.
- R7: Any write that does not match the next expected unlock or command cycle returns the block to array read.
- R8: The writes AAh@555h, 55h@2AAh, 90h@555h enter autoselect, and id_sel=1. id_data depends on rd_addr[7:0]: 00h gives MFR_CODE, 01h gives DEV_CODE, and 02h gives 01h or 00h from the protect bit of sector rd_addr[AW-1 -: SECT_BITS]. Any other offset gives 00h. Reads repeat without new writes.
- R9: Autoselect is left only by a write of F0h, at any address. Other writes leave id_sel=1.
- R10: The writes AAh@555h, 55h@2AAh, 20h@555h enter unlock bypass. There, A0h followed by data D at address A launches a program. When done, the block returns to bypass, so the next A0h/address-data pair programs again.
- R11: In bypass, a write of 90h followed by a write of 00h (any address) returns the block to array read. Afterwards, A0h plus an address/data write launches nothing.
- R12: Driving rst_n low during an embedded operation drops busy without waiting for a clock edge, and the block returns to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address for identification lookup |
| sect_prot | input | 2**SECT_BITS | Protect bit per sector |
| id_sel | output | 1 | Read mux select: 1 = identification data |
| id_data | output | DW | Identification byte for rd_addr |
| op_req | output | 1 | One-cycle launch of an embedded operation |
| op_erase | output | 1 | 1 = chip erase, 0 = program |
| op_addr | output | AW | Program address |
| op_data | output | DW | Program data |
| op_done | input | 1 | Array reports the embedded operation finished |
| busy | output | 1 | Ready/busy: 1 while an embedded operation runs |

## Verification
Each write is captured on one rising edge. The state, op_req, busy and id_sel it causes can therefore be seen on the falling edge that follows. The bench drives each write on a falling edge and checks on the next falling edge. busy is checked high while op_done is held and low one edge later, and op_req is confirmed low one edge after its launch. id_data follows rd_addr combinationally, so it is checked a short delay after rd_addr changes. The hardware reset is checked a short delay after rst_n falls, before any clock edge arrives.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int SECT_BITS = 4,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'hC4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  output logic                      id_sel,
  output logic [DW-1:0]             id_data,
  output logic                      op_req,
  output logic                      op_erase,
  output logic [AW-1:0]             op_addr,
  output logic [DW-1:0]             op_data,
  input  logic                      op_done,
  output logic                      busy
);
  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PGM, S_ES, S_EU1, S_EU2,
    S_AUTO, S_BYP, S_BPGM, S_BEX, S_BUSY
  } st_t;

  st_t  state;
  logic byp_ret;

  wire [7:0] cmd    = wr_data[7:0];
  wire       at_555 = wr_addr[10:0] == 11'h555;
  wire       u1_hit = cmd == 8'hAA && at_555;
  wire       u2_hit = cmd == 8'h55 && wr_addr[10:0] == 11'h2AA;
  wire       is_rst = cmd == 8'hF0;

  assign busy   = state == S_BUSY;
  assign id_sel = state == S_AUTO;

  always_comb begin
    id_data = '0;
    case (rd_addr[7:0])
      8'h00: id_data[7:0] = MFR_CODE;
      8'h01: id_data[7:0] = DEV_CODE;
      8'h02: id_data[0]   = sect_prot[rd_addr[AW-1 -: SECT_BITS]];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_READ;
      byp_ret  <= 1'b0;
      op_req   <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_req <= 1'b0;
      if (state == S_BUSY) begin
        if (op_done) state <= byp_ret ? S_BYP : S_READ;
      end else if (wr_en) begin
        case (state)
          S_READ: if (u1_hit) state <= S_U1;
          S_U1:   state <= u2_hit ? S_U2 : S_READ;
          S_U2: begin
            state <= S_READ;
            if (at_555)
              case (cmd)
                8'hA0: state <= S_PGM;
                8'h80: state <= S_ES;
                8'h90: state <= S_AUTO;
                8'h20: state <= S_BYP;
                default: ;
              endcase
          end
          S_PGM, S_BPGM: begin
            if (state == S_PGM && is_rst) state <= S_READ;
            else begin
              state    <= S_BUSY;
              op_req   <= 1'b1;
              op_erase <= 1'b0;
              op_addr  <= wr_addr;
              op_data  <= wr_data;
              byp_ret  <= state == S_BPGM;
            end
          end
          S_ES:  state <= u1_hit ? S_EU1 : S_READ;
          S_EU1: state <= u2_hit ? S_EU2 : S_READ;
          S_EU2: begin
            if (cmd == 8'h10 && at_555) begin
              state    <= S_BUSY;
              op_req   <= 1'b1;
              op_erase <= 1'b1;
              op_addr  <= '0;
              op_data  <= '1;
              byp_ret  <= 1'b0;
            end else state <= S_READ;
          end
          S_AUTO: if (is_rst) state <= S_READ;
          S_BYP: begin
            if (cmd == 8'hA0) state <= S_BPGM;
            else if (cmd == 8'h90) state <= S_BEX;
          end
          S_BEX: state <= (cmd == 8'h00) ? S_READ : S_BYP;
          default: state <= S_READ;
        endcase
      end
    end
  end

  // launch and busy rise together
  assert_req_with_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> busy);
  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> !op_req);
  assert_busy_ends_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(op_done));
  assert_op_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_addr) && $stable(op_data) && !op_req));
  assert_id_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_sel |-> !busy);
  assert_auto_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_sel) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'hF0));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 20, DW = 8, SB = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, op_done = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [(1<<SB)-1:0] sect_prot = 16'h0024;
  logic id_sel, op_req, op_erase, busy;
  logic [DW-1:0] id_data, op_data;
  logic [AW-1:0] op_addr;
  int total = 0, bad = 0;

  flash_cmd_decoder #(.AW(AW), .DW(DW), .SECT_BITS(SB)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .sect_prot(sect_prot), .id_sel(id_sel), .id_data(id_data),
    .op_req(op_req), .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data),
    .op_done(op_done), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic unlock(); wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); endtask

  task automatic finish_op(input string req);
    op_done = 1;
    chk(req, busy, 1);
    tick();
    op_done = 0;
    chk(req, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 op_req", op_req, 0); chk("R1 id_sel", id_sel, 0);
  endtask

  task automatic t_program();
    unlock(); wr(20'h00555, 8'hA0); wr(20'h3_1234, 8'h5A);
    chk("R2 req", op_req, 1); chk("R2 erase", op_erase, 0);
    chk("R2 addr", op_addr, 20'h3_1234); chk("R2 data", op_data, 8'h5A); chk("R2 busy", busy, 1);
    tick();
    chk("R2 req pulse", op_req, 0); chk("R4 busy held", busy, 1);
    finish_op("R4 done");
  endtask

  task automatic t_erase();
    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h00555, 8'h10);
    chk("R3 req", op_req, 1); chk("R3 erase", op_erase, 1);
    chk("R3 addr", op_addr, 0); chk("R3 data", op_data, 8'hFF);
    finish_op("R3 done");
  endtask

  task automatic t_busy_ignore();
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00010, 8'h11);
    wr(20'h00000, 8'hF0);
    chk("R5 F0 ignored", busy, 1);
    unlock();
    chk("R5 unlock ignored", busy, 1);
    finish_op("R5 done");
    wr(20'h00555, 8'hA0); wr(20'h00020, 8'h22);
    chk("R5 no stale seq", op_req, 0); chk("R5 no stale busy", busy, 0);
  endtask

  task automatic t_abort();
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00040, 8'hF0);
    chk("R6 pgm abort", busy, 0);
    wr(20'h00040, 8'h33); chk("R6 pgm abort read", op_req, 0);
    unlock(); wr(20'h00555, 8'h80); wr(20'h00555, 8'hAA); wr(20'h00000, 8'hF0);
    wr(20'h00555, 8'h10); chk("R6 erase abort", busy, 0);
    unlock(); wr(20'h00000, 8'hF0);
    wr(20'h00555, 8'h90); chk("R6 auto abort", id_sel, 0);
  endtask

  task automatic t_break();
    wr(20'h00555, 8'hAA); wr(20'h00123, 8'h55); wr(20'h00555, 8'hA0); wr(20'h00050, 8'h44);
    chk("R7 bad unlock addr", busy, 0);
    unlock(); wr(20'h00555, 8'h77); wr(20'h00555, 8'hA0); wr(20'h00050, 8'h44);
    chk("R7 bad command", busy, 0);
  endtask

  task automatic t_auto();
    unlock(); wr(20'h00555, 8'h90);
    chk("R8 id_sel", id_sel, 1);
    rd_addr = 20'h0_0000; #1 chk("R8 mfr", id_data, 8'h01);
    rd_addr = 20'h7_3301; #1 chk("R8 dev", id_data, 8'hC4);
    rd_addr = 20'h5_0002; #1 chk("R8 prot sect5", id_data, 8'h01);
    rd_addr = 20'h3_0002; #1 chk("R8 unprot sect3", id_data, 8'h00);
    rd_addr = 20'h0_0005; #1 chk("R8 other", id_data, 8'h00);
    rd_addr = 20'h0_0000; #1 chk("R8 repeat mfr", id_data, 8'h01);
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00060, 8'h66);
    chk("R9 stays auto", id_sel, 1); chk("R9 no op", busy, 0);
    wr(20'hA_BCDE, 8'hF0);
    chk("R9 F0 exits", id_sel, 0);
  endtask

  task automatic t_bypass();
    unlock(); wr(20'h00555, 8'h20);
    wr(20'h00000, 8'hA0); wr(20'h00070, 8'h77);
    chk("R10 req1", op_req, 1); chk("R10 addr1", op_addr, 20'h00070);
    finish_op("R10 done1");
    wr(20'h00000, 8'hA0); wr(20'h00071, 8'h78);
    chk("R10 req2", op_req, 1); chk("R10 data2", op_data, 8'h78);
    finish_op("R10 done2");
    wr(20'h00123, 8'h90); wr(20'h00456, 8'h00);
    wr(20'h00000, 8'hA0); wr(20'h00072, 8'h79);
    chk("R11 exit no req", op_req, 0); chk("R11 exit no busy", busy, 0);
  endtask

  task automatic t_hwreset();
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00080, 8'h88);
    chk("R12 busy", busy, 1);
    rst_n = 0; #1
    chk("R12 async drop", busy, 0);
    tick(); rst_n = 1; tick();
    chk("R12 read mode", id_sel, 0); chk("R12 idle", busy, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1; tick();
    t_program();
    t_erase();
    t_busy_ignore();
    t_abort();
    t_break();
    t_auto();
    t_bypass();
    t_hwreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule